// File: doc/BRIEF.md
# Operand Forwarding and Interlock Unit

This unit watches a five-stage in-order pipeline (fetch, decode/read, execute, memory, writeback) and resolves read-after-write conflicts. Other hazard kinds need no detection: results are written back in issue order, and only in the final stage. The unit looks at the instruction in the execute stage. Its source register indices are compared with the destination index of the instructions in the memory and writeback stages. From that comparison it steers the two execute-stage operand multiplexers to the register-file operand, the memory-stage result, or the writeback-stage result.

Some dependences cannot be covered by feeding results into the execute stage. One case is a loaded value needed by the next instruction. The other is a branch whose target register is still being produced while the branch is in decode. For these the unit raises a freeze that holds the fetch and decode registers. The same signal tells the pipeline to place a bubble into the execute stage, while the later stages keep moving.

The unit is purely combinational. Every output follows the stage fields presented in the same cycle. Register indices are `REG_W` bits wide.

Top module: `hz_unit`

## Requirements
- R1: Class code (3 bits) per stage: 0 idle, 1 arithmetic/logic, 2 address compute, 3 memory load, 4 memory store, 5 branch, 6 branch-and-link, 7 unused (treated as idle). Codes 1, 2, 3 and 6 write the register named by the destination field. Codes 1 to 6 read the first source field.
- R2: Each operand select is 2 bits: 0 keeps the stage-3 register/immediate operand, 1 takes the stage-4 result, 2 takes the stage-5 result. The value 3 never appears.
- R3: When stage 3 is valid and reads its first source, the first-operand select picks a valid producer in stage 4 or stage 5 whose destination equals that source. Otherwise it gives 0.
- R4: The second-operand select follows the same rule on the second source, but only when stage 3's immediate flag is 0. With the flag at 1 it gives 0.
- R5: When both stage 4 and stage 5 hold a matching producer, the select gives 1 (the younger result).
- R6: Only valid writing instructions forward. Stores, plain branches, idle or unused codes and invalid stages never do. A load in stage 4 is not a source, because its data is not ready. A load in stage 5 is a source. Register index 0 is matched like any other index.
- R7: Freeze is raised when stage 2 is valid, stage 3 holds a valid load, and the load's destination equals stage 2's first source, or its second source when stage 2's immediate flag is 0.
- R8: Freeze is also raised when stage 2 holds a valid branch (code 5 or 6) whose first source (target) equals the destination of one of these: a valid stage-3 arithmetic or address-compute instruction, a valid stage-3 load, or a valid stage-4 load.
- R9: In every other case freeze is 0. The bubble request equals freeze in every cycle.
- R10: All outputs are valid in the same cycle as the stage fields that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s2_valid | input | 1 | Stage 2 holds an instruction |
| s2_cls | input | 3 | Stage 2 class code |
| s2_rb | input | REG_W | Stage 2 first source index |
| s2_rc | input | REG_W | Stage 2 second source index |
| s2_imm | input | 1 | Stage 2 second operand is an immediate |
| s3_valid | input | 1 | Stage 3 holds an instruction |
| s3_cls | input | 3 | Stage 3 class code |
| s3_ra | input | REG_W | Stage 3 destination index |
| s3_rb | input | REG_W | Stage 3 first source index |
| s3_rc | input | REG_W | Stage 3 second source index |
| s3_imm | input | 1 | Stage 3 second operand is an immediate |
| s4_valid | input | 1 | Stage 4 holds an instruction |
| s4_cls | input | 3 | Stage 4 class code |
| s4_ra | input | REG_W | Stage 4 destination index |
| s5_valid | input | 1 | Stage 5 holds an instruction |
| s5_cls | input | 3 | Stage 5 class code |
| s5_ra | input | REG_W | Stage 5 destination index |
| fwd_x_sel | output | 2 | First ALU operand select |
| fwd_y_sel | output | 2 | Second ALU operand select |
| pause | output | 1 | Hold stage 1 and stage 2 registers |
| insert_nop | output | 1 | Load a bubble into stage 3 |

## Verification
No register lies between the stage fields and the outputs. Each result is therefore due in the same cycle as its stimulus. The bench changes the stage fields just after a rising edge and compares all four outputs at the next falling edge, half a period later. Directed cases cover each priority, the qualification rules and each freeze cause. A behavioural model then checks every cycle of a long run with a narrow register range, so that matches between stages are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [2:0] {
    CLS_NOP   = 3'd0,
    CLS_ALU   = 3'd1,
    CLS_LADR  = 3'd2,
    CLS_LOAD  = 3'd3,
    CLS_STORE = 3'd4,
    CLS_BR    = 3'd5,
    CLS_BRL   = 3'd6,
    CLS_RSVD  = 3'd7
  } op_cls_e;

  typedef enum logic [1:0] {
    SEL_OWN = 2'd0,
    SEL_Z4  = 2'd1,
    SEL_Z5  = 2'd2
  } fwd_sel_e;

  localparam int NUM_SRC = 2;

  // class writes its destination register at writeback
  function automatic logic writes_reg(op_cls_e c);
    return (c == CLS_ALU) || (c == CLS_LADR) || (c == CLS_LOAD) || (c == CLS_BRL);
  endfunction

  // class whose result already sits in the stage-4 register
  function automatic logic early_result(op_cls_e c);
    return (c == CLS_ALU) || (c == CLS_LADR) || (c == CLS_BRL);
  endfunction

  // class reads its first source field
  function automatic logic reads_src(op_cls_e c);
    return (c != CLS_NOP) && (c != CLS_RSVD);
  endfunction

  function automatic logic is_branch(op_cls_e c);
    return (c == CLS_BR) || (c == CLS_BRL);
  endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             src_used,
  input  logic [REG_W-1:0] src_idx,
  input  logic             z4_en,
  input  logic [REG_W-1:0] z4_ra,
  input  logic             z5_en,
  input  logic [REG_W-1:0] z5_ra,
  output logic [1:0]       sel
);

  logic hit4, hit5;

  assign hit4 = src_used && z4_en && (z4_ra == src_idx);
  assign hit5 = src_used && z5_en && (z5_ra == src_idx);

  // younger stage-4 result wins over stage-5
  always_comb begin
    sel = SEL_OWN;
    if (hit4)      sel = SEL_Z4;
    else if (hit5) sel = SEL_Z5;
  end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             s2_valid,
  input  logic [2:0]       s2_cls,
  input  logic [REG_W-1:0] s2_rb,
  input  logic [REG_W-1:0] s2_rc,
  input  logic             s2_imm,
  input  logic             s3_valid,
  input  logic [2:0]       s3_cls,
  input  logic [REG_W-1:0] s3_ra,
  input  logic             s4_valid,
  input  logic [2:0]       s4_cls,
  input  logic [REG_W-1:0] s4_ra,
  output logic             stall
);

  op_cls_e c2, c3, c4;
  logic rb_rd, rc_rd;
  logic s3_ld, s3_early, s4_ld;
  logic load_use, br_tgt;

  assign c2 = op_cls_e'(s2_cls);
  assign c3 = op_cls_e'(s3_cls);
  assign c4 = op_cls_e'(s4_cls);

  assign rb_rd    = s2_valid && reads_src(c2);
  assign rc_rd    = rb_rd && !s2_imm;
  assign s3_ld    = s3_valid && (c3 == CLS_LOAD);
  assign s3_early = s3_valid && ((c3 == CLS_ALU) || (c3 == CLS_LADR));
  assign s4_ld    = s4_valid && (c4 == CLS_LOAD);

  // loaded data appears only at the end of stage 4
  assign load_use = s3_ld && ((rb_rd && (s3_ra == s2_rb)) ||
                              (rc_rd && (s3_ra == s2_rc)));

  // branch target is consumed in stage 2, beyond forwarding reach
  assign br_tgt = s2_valid && is_branch(c2) &&
                  ((((s3_early || s3_ld) && (s3_ra == s2_rb))) ||
                   (s4_ld && (s4_ra == s2_rb)));

  assign stall = load_use || br_tgt;

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             s2_valid,
  input  logic [2:0]       s2_cls,
  input  logic [REG_W-1:0] s2_rb,
  input  logic [REG_W-1:0] s2_rc,
  input  logic             s2_imm,
  input  logic             s3_valid,
  input  logic [2:0]       s3_cls,
  input  logic [REG_W-1:0] s3_ra,
  input  logic [REG_W-1:0] s3_rb,
  input  logic [REG_W-1:0] s3_rc,
  input  logic             s3_imm,
  input  logic             s4_valid,
  input  logic [2:0]       s4_cls,
  input  logic [REG_W-1:0] s4_ra,
  input  logic             s5_valid,
  input  logic [2:0]       s5_cls,
  input  logic [REG_W-1:0] s5_ra,
  output logic [1:0]       fwd_x_sel,
  output logic [1:0]       fwd_y_sel,
  output logic             pause,
  output logic             insert_nop
);

  logic z4_en, z5_en, s3_reads;
  logic             src_used [NUM_SRC];
  logic [REG_W-1:0] src_idx  [NUM_SRC];
  logic [1:0]       src_sel  [NUM_SRC];
  logic             stall;

  // stage-3 destination is not a forwarding source; s3_ra feeds only the stall path
  assign z4_en    = s4_valid && early_result(op_cls_e'(s4_cls));
  assign z5_en    = s5_valid && writes_reg(op_cls_e'(s5_cls));
  assign s3_reads = s3_valid && reads_src(op_cls_e'(s3_cls));

  assign src_used[0] = s3_reads;
  assign src_idx[0]  = s3_rb;
  assign src_used[1] = s3_reads && !s3_imm;
  assign src_idx[1]  = s3_rc;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hz_src_match #(.REG_W(REG_W)) u_match (
      .src_used (src_used[i]),
      .src_idx  (src_idx[i]),
      .z4_en    (z4_en),
      .z4_ra    (s4_ra),
      .z5_en    (z5_en),
      .z5_ra    (s5_ra),
      .sel      (src_sel[i])
    );
  end

  hz_stall_detect #(.REG_W(REG_W)) u_stall (
    .s2_valid (s2_valid),
    .s2_cls   (s2_cls),
    .s2_rb    (s2_rb),
    .s2_rc    (s2_rc),
    .s2_imm   (s2_imm),
    .s3_valid (s3_valid),
    .s3_cls   (s3_cls),
    .s3_ra    (s3_ra),
    .s4_valid (s4_valid),
    .s4_cls   (s4_cls),
    .s4_ra    (s4_ra),
    .stall    (stall)
  );

  assign fwd_x_sel  = src_sel[0];
  assign fwd_y_sel  = src_sel[1];
  assign pause      = stall;
  assign insert_nop = stall;

endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             s2_valid,
  input logic [2:0]       s2_cls,
  input logic [REG_W-1:0] s2_rb,
  input logic [REG_W-1:0] s2_rc,
  input logic             s2_imm,
  input logic             s3_valid,
  input logic [2:0]       s3_cls,
  input logic [REG_W-1:0] s3_ra,
  input logic [REG_W-1:0] s3_rb,
  input logic [REG_W-1:0] s3_rc,
  input logic             s3_imm,
  input logic             s4_valid,
  input logic [2:0]       s4_cls,
  input logic [REG_W-1:0] s4_ra,
  input logic             s5_valid,
  input logic [2:0]       s5_cls,
  input logic [REG_W-1:0] s5_ra,
  input logic [1:0]       fwd_x_sel,
  input logic [1:0]       fwd_y_sel,
  input logic             pause
);

  logic s3_alu_reg, s4_alu, s5_alu, s2_alu, s3_ld;

  assign s3_alu_reg = s3_valid && (s3_cls == CLS_ALU) && !s3_imm;
  assign s4_alu     = s4_valid && (s4_cls == CLS_ALU);
  assign s5_alu     = s5_valid && (s5_cls == CLS_ALU);
  assign s2_alu     = s2_valid && (s2_cls == CLS_ALU) && !s2_imm;
  assign s3_ld      = s3_valid && (s3_cls == CLS_LOAD);

  always_comb begin
    AST_SEL_LEGAL: assert (fwd_x_sel != 2'd3 && fwd_y_sel != 2'd3); // R2
    if (s3_alu_reg && s4_alu && s4_ra == s3_rb)
      AST_X_FROM_Z4: assert (fwd_x_sel == 2'd1); // R3
    if (s3_alu_reg && s5_alu && s5_ra == s3_rc && !(s4_valid && s4_ra == s3_rc))
      AST_Y_FROM_Z5: assert (fwd_y_sel == 2'd2); // R4
    if (s3_imm)
      AST_Y_IMM_OWN: assert (fwd_y_sel == 2'd0); // R4
    if (s3_alu_reg && s4_alu && s5_alu && s4_ra == s3_rb && s5_ra == s3_rb)
      AST_Z4_PRIORITY: assert (fwd_x_sel == 2'd1); // R5
    if (!s3_valid)
      AST_IDLE_NO_FWD: assert (fwd_x_sel == 2'd0 && fwd_y_sel == 2'd0); // R6
    if (s2_alu && s3_ld && (s3_ra == s2_rb || s3_ra == s2_rc))
      AST_LOAD_USE_PAUSE: assert (pause); // R7
    if (s2_valid && s2_cls == CLS_BR && s4_valid && s4_cls == CLS_LOAD && s4_ra == s2_rb)
      AST_BR_LOAD2_PAUSE: assert (pause); // R8
    if (!s2_valid)
      AST_NO_PAUSE_IDLE: assert (!pause); // R9
  end

endmodule

bind hz_unit hz_unit_chk #(.REG_W(REG_W)) u_chk (
  .s2_valid (s2_valid),
  .s2_cls   (s2_cls),
  .s2_rb    (s2_rb),
  .s2_rc    (s2_rc),
  .s2_imm   (s2_imm),
  .s3_valid (s3_valid),
  .s3_cls   (s3_cls),
  .s3_ra    (s3_ra),
  .s3_rb    (s3_rb),
  .s3_rc    (s3_rc),
  .s3_imm   (s3_imm),
  .s4_valid (s4_valid),
  .s4_cls   (s4_cls),
  .s4_ra    (s4_ra),
  .s5_valid (s5_valid),
  .s5_cls   (s5_cls),
  .s5_ra    (s5_ra),
  .fwd_x_sel(fwd_x_sel),
  .fwd_y_sel(fwd_y_sel),
  .pause    (pause)
);

// File: tb/hz_unit_test.sv
module hz_unit_test;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          s2_valid, s2_imm, s3_valid, s3_imm, s4_valid, s5_valid;
  logic [2:0]    s2_cls, s3_cls, s4_cls, s5_cls;
  logic [RW-1:0] s2_rb, s2_rc, s3_ra, s3_rb, s3_rc, s4_ra, s5_ra;
  logic [1:0]    fwd_x_sel, fwd_y_sel;
  logic          pause, insert_nop;

  hz_unit #(.REG_W(RW)) uut (
    .s2_valid(s2_valid), .s2_cls(s2_cls), .s2_rb(s2_rb), .s2_rc(s2_rc), .s2_imm(s2_imm),
    .s3_valid(s3_valid), .s3_cls(s3_cls), .s3_ra(s3_ra), .s3_rb(s3_rb), .s3_rc(s3_rc),
    .s3_imm(s3_imm), .s4_valid(s4_valid), .s4_cls(s4_cls), .s4_ra(s4_ra),
    .s5_valid(s5_valid), .s5_cls(s5_cls), .s5_ra(s5_ra),
    .fwd_x_sel(fwd_x_sel), .fwd_y_sel(fwd_y_sel), .pause(pause), .insert_nop(insert_nop)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference, written from the requirement list
  function automatic int pick(int r);
    if (s4_valid && (s4_cls == 1 || s4_cls == 2 || s4_cls == 6) && s4_ra == r) return 1;
    if (s5_valid && (s5_cls == 1 || s5_cls == 2 || s5_cls == 3 || s5_cls == 6) && s5_ra == r) return 2;
    return 0;
  endfunction

  function automatic int mdl_x();
    if (!s3_valid || s3_cls == 0 || s3_cls == 7) return 0;
    return pick(int'(s3_rb));
  endfunction

  function automatic int mdl_y();
    if (!s3_valid || s3_cls == 0 || s3_cls == 7 || s3_imm) return 0;
    return pick(int'(s3_rc));
  endfunction

  function automatic int mdl_pause();
    if (!s2_valid || s2_cls == 0 || s2_cls == 7) return 0;
    if (s3_valid && s3_cls == 3 && (s3_ra == s2_rb || (!s2_imm && s3_ra == s2_rc))) return 1;
    if (s2_cls == 5 || s2_cls == 6) begin
      if (s3_valid && (s3_cls == 1 || s3_cls == 2 || s3_cls == 3) && s3_ra == s2_rb) return 1;
      if (s4_valid && s4_cls == 3 && s4_ra == s2_rb) return 1;
    end
    return 0;
  endfunction

  task automatic idle();
    s2_valid = 0; s2_cls = 0; s2_rb = 0; s2_rc = 0; s2_imm = 0;
    s3_valid = 0; s3_cls = 0; s3_ra = 0; s3_rb = 0; s3_rc = 0; s3_imm = 0;
    s4_valid = 0; s4_cls = 0; s4_ra = 0;
    s5_valid = 0; s5_cls = 0; s5_ra = 0;
  endtask

  // sampled half a period after the stimulus: same-cycle result (R10)
  task automatic expect_all(string req, int ex, int ey, int ep);
    @(negedge clk);
    chk(req, "fwd_x_sel", int'(fwd_x_sel), ex);
    chk(req, "fwd_y_sel", int'(fwd_y_sel), ey);
    chk(req, "pause", int'(pause), ep);
    chk("R9", "insert_nop", int'(insert_nop), ep);
  endtask

  task automatic s3_alu(int rb, int rc, bit imm);
    s3_valid = 1; s3_cls = 3'd1; s3_ra = 5'd20; s3_rb = RW'(rb); s3_rc = RW'(rc); s3_imm = imm;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    expect_all("R9", 0, 0, 0);                        // reset/idle state

    @(posedge clk); idle(); s3_alu(3, 4, 0);
    s4_valid = 1; s4_cls = 3'd1; s4_ra = 5'd3;
    expect_all("R3", 1, 0, 0);

    @(posedge clk); idle(); s3_alu(3, 4, 0);
    s5_valid = 1; s5_cls = 3'd3; s5_ra = 5'd4;       // stage-5 load forwards
    expect_all("R4", 0, 2, 0);

    @(posedge clk); idle(); s3_alu(3, 4, 1);
    s4_valid = 1; s4_cls = 3'd1; s4_ra = 5'd4;       // immediate blocks Y
    expect_all("R4", 0, 0, 0);

    @(posedge clk); idle(); s3_alu(3, 3, 0);
    s4_valid = 1; s4_cls = 3'd2; s4_ra = 5'd3;
    s5_valid = 1; s5_cls = 3'd1; s5_ra = 5'd3;
    expect_all("R5", 1, 1, 0);

    @(posedge clk); idle(); s3_alu(3, 9, 0);
    s4_valid = 1; s4_cls = 3'd4; s4_ra = 5'd3;       // store ignored
    s5_valid = 1; s5_cls = 3'd1; s5_ra = 5'd3;
    expect_all("R6", 2, 0, 0);

    @(posedge clk); idle(); s3_alu(3, 9, 0);
    s4_valid = 1; s4_cls = 3'd3; s4_ra = 5'd3;       // stage-4 load not a source
    expect_all("R6", 0, 0, 0);

    @(posedge clk); idle(); s3_alu(0, 9, 0);
    s4_valid = 1; s4_cls = 3'd6; s4_ra = 5'd0;       // register 0 ordinary
    expect_all("R6", 1, 0, 0);

    @(posedge clk); idle(); s3_alu(3, 9, 0);
    s4_valid = 0; s4_cls = 3'd1; s4_ra = 5'd3;       // invalid producer
    s5_valid = 1; s5_cls = 3'd5; s5_ra = 5'd3;       // plain branch
    expect_all("R6", 0, 0, 0);

    @(posedge clk); idle();
    s2_valid = 1; s2_cls = 3'd1; s2_rb = 5'd7; s2_rc = 5'd1;
    s3_valid = 1; s3_cls = 3'd3; s3_ra = 5'd7;
    expect_all("R7", 0, 0, 1);

    @(posedge clk); idle();
    s2_valid = 1; s2_cls = 3'd1; s2_rb = 5'd1; s2_rc = 5'd7; s2_imm = 1;
    s3_valid = 1; s3_cls = 3'd3; s3_ra = 5'd7;       // rc unused
    expect_all("R7", 0, 0, 0);

    @(posedge clk); idle();
    s2_valid = 1; s2_cls = 3'd5; s2_rb = 5'd9; s2_imm = 1;
    s3_valid = 1; s3_cls = 3'd1; s3_ra = 5'd9; s3_imm = 1;
    expect_all("R8", 0, 0, 1);

    @(posedge clk); idle();
    s2_valid = 1; s2_cls = 3'd6; s2_rb = 5'd9; s2_imm = 1;
    s4_valid = 1; s4_cls = 3'd3; s4_ra = 5'd9;
    expect_all("R8", 0, 0, 1);

    @(posedge clk); idle();
    s2_valid = 1; s2_cls = 3'd5; s2_rb = 5'd9; s2_imm = 1;
    s4_valid = 1; s4_cls = 3'd1; s4_ra = 5'd9;       // stage-4 ALU: no freeze
    expect_all("R8", 0, 0, 0);

    @(posedge clk); idle();
    s2_valid = 0; s2_cls = 3'd1; s2_rb = 5'd7;
    s3_valid = 1; s3_cls = 3'd3; s3_ra = 5'd7; s3_imm = 1;
    expect_all("R9", 0, 0, 0);

    // R1 R10: randomized stream, reference model every cycle
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk);
      s2_valid = 1'($urandom_range(0, 1)); s2_cls = 3'($urandom_range(0, 7));
      s2_rb = RW'($urandom_range(0, 3)); s2_rc = RW'($urandom_range(0, 3));
      s2_imm = 1'($urandom_range(0, 1));
      s3_valid = 1'($urandom_range(0, 1)); s3_cls = 3'($urandom_range(0, 7));
      s3_ra = RW'($urandom_range(0, 3)); s3_rb = RW'($urandom_range(0, 3));
      s3_rc = RW'($urandom_range(0, 3)); s3_imm = 1'($urandom_range(0, 1));
      s4_valid = 1'($urandom_range(0, 1)); s4_cls = 3'($urandom_range(0, 7));
      s4_ra = RW'($urandom_range(0, 3));
      s5_valid = 1'($urandom_range(0, 1)); s5_cls = 3'($urandom_range(0, 7));
      s5_ra = RW'($urandom_range(0, 3));
      @(negedge clk);
      chk("R3", "fwd_x_sel", int'(fwd_x_sel), mdl_x());
      chk("R4", "fwd_y_sel", int'(fwd_y_sel), mdl_y());
      chk("R7_R8", "pause", int'(pause), mdl_pause());
      chk("R9", "insert_nop", int'(insert_nop), mdl_pause());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule